// File: doc/BRIEF.md
# Receive Word FIFO with Cable Flow Control

This block buffers 16-bit words arriving from an external device on the receive side of a streaming interface. The device presents a word together with a data-valid strobe. The block stores each such word in a first-in first-out buffer, and the host side drains the buffer through a show-ahead read port. A hold signal goes back to the device once the buffer reaches a programmable fill threshold. The threshold sits below the full depth, so words already travelling in the cable still find room after the device sees the hold.

A single enable input acts as the interface enable bit of the command register. While it is low, the buffer is kept empty, incoming words are ignored and the error flag is cleared. Taking enable low and then high again is therefore the only way to clear a recorded overflow. An 8-bit status byte reports the live level of the valid strobe, an almost-full flag, a two-bit full field and a sticky overflow flag.

Top module: `rx_word_fifo`

## Requirements
- R1: While `link_en` is low, `rd_avail` is 0, `dev_hold` is 0, status bits 6..3 are 0, and words strobed by `dev_valid` are not stored, so they are not readable after enable returns.
- R2: With `link_en` high, each clock edge where `dev_valid` is high and the buffer is not full stores `dev_data`. Stored words appear on `rd_data` in arrival order while `rd_avail` is high, and each edge with `rd_en` high and `rd_avail` high removes the front word.
- R3: Status bits 5 and 4 are both 1 exactly when the buffer holds DEPTH words, and both 0 otherwise.
- R4: Status bit 6 is 1 exactly when the number of stored words is at least AFULL_LVL (default DEPTH-8).
- R5: `dev_hold` is 1 exactly when the number of stored words is at least AFULL_LVL, and 0 below it.
- R6: A word that arrives while the buffer is full is dropped, and the words already stored read out unchanged and in order.
- R7: Status bit 3 (overflow) becomes 1 on the edge after a clock edge where `link_en` and `dev_valid` are high and the buffer is full. It then stays 1 while `link_en` stays high, including after the buffer drains.
- R8: One clock edge with `link_en` low clears the overflow flag and empties the buffer.
- R9: Status bit 7 follows `dev_valid` in the same cycle, and status bits 2..0 read 0.
- R10: Fullness is judged on the level at the start of the cycle. A word that arrives while the buffer is full is dropped and sets overflow even when a read happens on the same edge, and that edge leaves DEPTH-1 words stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_en | input | 1 | Interface enable, command register bit 3 |
| dev_data | input | 16 | Word from the device |
| dev_valid | input | 1 | Device data-valid strobe |
| dev_hold | output | 1 | Board-not-ready back to the device |
| rd_en | input | 1 | Host pop request |
| rd_data | output | 16 | Front word of the buffer (show-ahead) |
| rd_avail | output | 1 | Buffer holds at least one word |
| status | output | 8 | Data path status byte |

## Verification
Level-derived results are due one edge after the stimulus: `dev_hold`, status bits 6..3 and `rd_avail` all come from registers updated at that edge. Status bit 7 and the front word on `rd_data` are combinational and are due in the same cycle. The bench applies inputs at the falling edge and reads registered results at the next falling edge, after exactly one rising edge. It reads `rd_data` and status bit 7 at a falling edge before the rising edge that would consume or change them.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Status byte bit positions
  localparam int STAT_VALID_BIT = 7;
  localparam int STAT_AFULL_BIT = 6;
  localparam int STAT_FULL_HI   = 5;
  localparam int STAT_FULL_LO   = 4;
  localparam int STAT_OVF_BIT   = 3;

  // Next fill level after one edge
  function automatic int lvl_next(input int lvl, input logic push, input logic pop);
    int r;
    r = lvl;
    if (push && !pop) r = lvl + 1;
    else if (pop && !push) r = lvl - 1;
    return r;
  endfunction

  // Circular pointer advance
  function automatic int ptr_inc(input int ptr, input int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

  // Pack the status byte
  function automatic logic [7:0] stat_pack(input logic valid, input logic afull,
                                            input logic full, input logic ovf);
    logic [7:0] s;
    s = 8'h00;
    s[STAT_VALID_BIT] = valid;
    s[STAT_AFULL_BIT] = afull;
    s[STAT_FULL_HI]   = full;
    s[STAT_FULL_LO]   = full;
    s[STAT_OVF_BIT]   = ovf;
    return s;
  endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= AW'(rxf_pkg::ptr_inc(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= AW'(rxf_pkg::ptr_inc(int'(rd_ptr), DEPTH));
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];
endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
  parameter int DEPTH     = 32,
  parameter int AFULL_LVL = DEPTH - 8,
  parameter int LW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          afull,
  output logic          empty
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) level <= '0;
    else               level <= LW'(rxf_pkg::lvl_next(int'(level), push, pop));
  end

  assign full  = (int'(level) == DEPTH);
  assign afull = (int'(level) >= AFULL_LVL);
  assign empty = (level == '0);
endmodule

// File: rtl/rxf_sticky.sv
module rxf_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) flag <= 1'b0;
    else if (set)      flag <= 1'b1;
  end
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 32,
  parameter int AFULL_LVL = DEPTH - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_en,
  input  logic [DATA_W-1:0] dev_data,
  input  logic              dev_valid,
  output logic              dev_hold,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_avail,
  output logic [7:0]        status
);
  localparam int LW = $clog2(DEPTH + 1);

  // Named internal events
  logic          hold_clr;
  logic          push_fire;
  logic          pop_fire;
  logic          ovf_event;
  logic          lvl_full;
  logic          lvl_afull;
  logic          lvl_empty;
  logic          ovf_flag;
  logic [LW-1:0] fill_lvl;

  assign hold_clr  = ~link_en;
  assign push_fire = link_en & dev_valid & ~lvl_full;
  assign pop_fire  = link_en & rd_en & ~lvl_empty;
  assign ovf_event = link_en & dev_valid & lvl_full;

  rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hold_clr),
    .push  (push_fire),
    .pop   (pop_fire),
    .wdata (dev_data),
    .rdata (rd_data)
  );

  rxf_level #(.DEPTH(DEPTH), .AFULL_LVL(AFULL_LVL), .LW(LW)) u_level (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hold_clr),
    .push  (push_fire),
    .pop   (pop_fire),
    .level (fill_lvl),
    .full  (lvl_full),
    .afull (lvl_afull),
    .empty (lvl_empty)
  );

  rxf_sticky u_ovf (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hold_clr),
    .set   (ovf_event),
    .flag  (ovf_flag)
  );

  assign dev_hold = lvl_afull;
  assign rd_avail = ~lvl_empty;
  assign status   = rxf_pkg::stat_pack(dev_valid, lvl_afull, lvl_full, ovf_flag);
endmodule

// File: rtl/rx_word_fifo_chk.sv
module rx_word_fifo_chk #(
  parameter int DEPTH     = 32,
  parameter int AFULL_LVL = DEPTH - 8,
  parameter int LW        = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          link_en,
  input logic          dev_valid,
  input logic          dev_hold,
  input logic          rd_avail,
  input logic [7:0]    status,
  input logic          push_fire,
  input logic          pop_fire,
  input logic [LW-1:0] fill_lvl
);
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en |=> (!rd_avail && !status[3])); // R8

  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |-> (int'(fill_lvl) != DEPTH)); // R6

  AST_HOLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_hold) |-> $past(push_fire)); // R5

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (link_en && dev_valid && int'(fill_lvl) == DEPTH) |=> status[3]); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && link_en) |=> (status[3] || !$past(link_en))); // R7

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && !pop_fire) |=> (int'(fill_lvl) == int'($past(fill_lvl)) + 1)); // R2

  AST_VALID_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] == dev_valid); // R9
endmodule

bind rx_word_fifo rx_word_fifo_chk #(.DEPTH(DEPTH), .AFULL_LVL(AFULL_LVL), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .link_en   (link_en),
  .dev_valid (dev_valid),
  .dev_hold  (dev_hold),
  .rd_avail  (rd_avail),
  .status    (status),
  .push_fire (push_fire),
  .pop_fire  (pop_fire),
  .fill_lvl  (fill_lvl)
);

// File: tb/rx_word_fifo_test.sv
`timescale 1ns/1ps
module rx_word_fifo_test;
  localparam int DEPTH = 32;
  localparam int AFL   = DEPTH - 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_en = 1'b0;
  logic [15:0] dev_data = '0;
  logic        dev_valid = 1'b0;
  logic        rd_en = 1'b0;
  logic        dev_hold;
  logic [15:0] rd_data;
  logic        rd_avail;
  logic [7:0]  status;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  rx_word_fifo #(.DATA_W(16), .DEPTH(DEPTH), .AFULL_LVL(AFL)) uut (
    .clk(clk), .rst_n(rst_n), .link_en(link_en), .dev_data(dev_data),
    .dev_valid(dev_valid), .dev_hold(dev_hold), .rd_en(rd_en),
    .rd_data(rd_data), .rd_avail(rd_avail), .status(status)
  );

  typedef struct packed {
    logic        en;
    logic        v;
    logic        rd;
    logic [15:0] d;
    logic        avail;
    logic [15:0] head;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b1, 1'b0, 16'hA001, 1'b1, 16'hA001},
    '{1'b1, 1'b1, 1'b0, 16'hA002, 1'b1, 16'hA001},
    '{1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 16'hA002},
    '{1'b1, 1'b1, 1'b1, 16'hA003, 1'b1, 16'hA003},
    '{1'b1, 1'b0, 1'b1, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 1'b1, 1'b0, 16'h5A5A, 1'b1, 16'h5A5A},
    '{1'b0, 1'b1, 1'b0, 16'hFFFF, 1'b0, 16'h0000},
    '{1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge: apply inputs, pass one rising edge, return at the next falling edge
  task automatic drive(input logic en, input logic v, input logic [15:0] d, input logic rd);
    link_en = en; dev_valid = v; dev_data = d; rd_en = rd;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state, R1
    check("R1 reset avail", rd_avail, 0);
    check("R1 reset hold", dev_hold, 0);
    check("R1 reset status", status, 8'h00);

    // Vector table, R2 / R1
    for (int i = 0; i < 8; i++) begin
      drive(VECS[i].en, VECS[i].v, VECS[i].d, VECS[i].rd);
      check("R2 avail", rd_avail, VECS[i].avail);
      if (VECS[i].avail) check("R2 head", rd_data, VECS[i].head);
    end
    drive(1, 0, 0, 0);

    // Fill to threshold, R4 R5 R3
    for (int i = 0; i < AFL - 1; i++) drive(1, 1, 16'h1000 + 16'(i), 0);
    check("R5 below threshold hold", dev_hold, 0);
    check("R4 below threshold bit6", status[6], 0);
    drive(1, 1, 16'h1000 + 16'(AFL - 1), 0);
    check("R5 at threshold hold", dev_hold, 1);
    check("R4 at threshold bit6", status[6], 1);
    check("R3 not full", status[5:4], 2'b00);
    for (int i = AFL; i < DEPTH; i++) drive(1, 1, 16'h1000 + 16'(i), 0);
    check("R3 full bits", status[5:4], 2'b11);
    check("R7 no ovf yet", status[3], 0);
    drive(1, 1, 16'hDEAD, 0);
    check("R7 ovf set", status[3], 1);
    check("R6 still full", status[5:4], 2'b11);
    for (int i = 0; i < DEPTH; i++) begin
      check("R6 order", rd_data, 16'h1000 + 16'(i));
      drive(1, 0, 0, 1);
    end
    check("R6 drained", rd_avail, 0);
    check("R7 ovf sticky", status[3], 1);
    check("R5 hold released", dev_hold, 0);

    // R9 live valid bit
    link_en = 1; dev_valid = 1; dev_data = 16'h7777; rd_en = 0;
    #1;
    check("R9 bit7 high", status[7], 1);
    check("R9 low bits", status[2:0], 3'b000);
    @(posedge clk); @(negedge clk);
    dev_valid = 0;
    #1;
    check("R9 bit7 low", status[7], 0);
    @(negedge clk);

    // R8 enable toggle clears
    drive(0, 0, 0, 0);
    check("R8 ovf cleared", status[3], 0);
    check("R8 emptied", rd_avail, 0);
    drive(0, 1, 16'hBEEF, 0);
    check("R1 ignored while off", rd_avail, 0);
    check("R1 status while off", status[6:3], 4'h0);
    drive(1, 0, 0, 0);
    check("R1 nothing stored", rd_avail, 0);

    // R10 full with simultaneous pop
    for (int i = 0; i < DEPTH; i++) drive(1, 1, 16'h2000 + 16'(i), 0);
    check("R10 full first", status[5:4], 2'b11);
    check("R10 head", rd_data, 16'h2000);
    drive(1, 1, 16'hDEAD, 1);
    check("R10 ovf", status[3], 1);
    check("R10 level dropped", status[5:4], 2'b00);
    for (int i = 1; i < DEPTH; i++) begin
      check("R10 order", rd_data, 16'h2000 + 16'(i));
      drive(1, 0, 0, 1);
    end
    check("R10 empty after", rd_avail, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule